// File: doc/BRIEF.md
# Set-Associative Address Translation Cache

This block caches address translations for a 32-bit virtual address space with 4 KB pages. A lookup presents a 20-bit virtual page number and a 12-bit page offset. The page number selects one set and is compared against all four ways of that set in the same cycle. A matching table-level entry gives the physical address and the entry's low permission bits. A matching directory-level entry is reported on a separate output, so that an external walker can skip the first level of its walk.

On a miss, the walker fetches the missing word and writes it back through the refill port, marking it as a directory-level or table-level word. A refill takes the lowest free way in the set. When the set is full, a three-bit tree pseudo-LRU per set chooses the way to replace. There are two flush inputs. The task-switch flush drops every entry except those whose cached word has its global bit set. The invalidate-all flush empties the whole buffer.

Top module: `xc_tlb`

## Requirements
- R1: After reset every lookup reports hit=0, dir_hit=0 and miss=1.
- R2: The set index is vpn[3:0] and the tag is vpn[19:4]. Page numbers that share a set index but differ in tag are separate entries, and a lookup with a different tag misses.
- R3: A lookup that matches a valid table-level entry (flag 0) gives hit=1 and miss=0, pa = {word[31:12], offset} and perm = word[11:0].
- R4: A lookup that matches only a valid directory-level entry (flag 1) gives hit=0, miss=1, dir_hit=1, and dir_word equal to the cached word.
- R5: When one set holds both a directory-level and a table-level entry with the same tag, the translation comes from the table-level entry, and dir_hit is still 1.
- R6: A refill writes the lowest-numbered invalid way of its set.
- R7: In a full set, the victim follows a three-bit tree. The root bit chooses ways 0-1 (0) or ways 2-3 (1). The left-pair bit chooses way 0 (0) or way 1 (1). The right-pair bit chooses way 2 (0) or way 3 (1). Every lookup hit and every refill points the tree away from the way it used. The bits are 0 after reset.
- R8: flush_task invalidates, in one cycle, every valid entry whose word has bit 8 clear. Entries with bit 8 set remain usable.
- R9: flush_all invalidates every entry, global ones included, in one cycle.
- R10: A refill presented in the same cycle as either flush is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_en | input | 1 | Lookup request; qualifies outputs and pseudo-LRU touch |
| lk_vpn | input | 20 | Virtual page number to translate |
| lk_off | input | 12 | Page offset, passed through to pa |
| hit | output | 1 | Table-level translation found |
| miss | output | 1 | Lookup active and no table-level translation |
| pa | output | 32 | Physical address on hit |
| perm | output | 12 | Low 12 bits of the hitting table-level word |
| dir_hit | output | 1 | Matching directory-level entry found |
| dir_word | output | 32 | Cached directory-level word |
| fill_en | input | 1 | Refill strobe |
| fill_is_dir | input | 1 | 1: directory-level word, 0: table-level word |
| fill_vpn | input | 20 | Page number the refill belongs to |
| fill_word | input | 32 | Word to cache |
| flush_task | input | 1 | Task-switch flush, keeps global entries |
| flush_all | input | 1 | Invalidate every entry |

## Verification
The bench uses the default build of 16 sets and a 20-bit page number. With these values a single set, set 3, can be filled through all four ways with tags 1 to 4. That reaches the step where free ways run out and the tree victim decides. One hit on tag 1, made before the fifth refill, moves the victim from way 0 to way 2, so the outcome shows both that the tree was touched and which leaf it chose. The same build keeps global and non-global words, and directory and table words, side by side in one set and in neighbouring sets, to exercise both flushes and the table-over-directory priority.

// File: rtl/xc_pkg.sv
package xc_pkg;
  localparam int WAYS       = 4;
  localparam int WAY_W      = 2;
  localparam int PLRU_W     = 3;
  localparam int OFF_W      = 12;
  localparam int GLOBAL_BIT = 8;
endpackage

// File: rtl/xc_way_match.sv
module xc_way_match
  import xc_pkg::*;
#(
  parameter int TAG_W  = 16,
  parameter int WORD_W = 32
) (
  input  logic [WAYS-1:0]             vld,
  input  logic [WAYS-1:0]             is_dir,
  input  logic [WAYS-1:0][TAG_W-1:0]  tags,
  input  logic [WAYS-1:0][WORD_W-1:0] words,
  input  logic [TAG_W-1:0]            key,
  output logic                        pte_any,
  output logic [WAY_W-1:0]            pte_way,
  output logic [WORD_W-1:0]           pte_word,
  output logic                        pde_any,
  output logic [WAY_W-1:0]            pde_way,
  output logic [WORD_W-1:0]           pde_word
);
  logic [WAYS-1:0] eq;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign eq[w] = vld[w] && (tags[w] == key);
  end

  always_comb begin
    pte_any  = 1'b0;
    pte_way  = '0;
    pte_word = '0;
    pde_any  = 1'b0;
    pde_way  = '0;
    pde_word = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (eq[w] && !is_dir[w]) begin
        pte_any  = 1'b1;
        pte_way  = WAY_W'(w);
        pte_word = words[w];
      end
      if (eq[w] && is_dir[w]) begin
        pde_any  = 1'b1;
        pde_way  = WAY_W'(w);
        pde_word = words[w];
      end
    end
  end
endmodule

// File: rtl/xc_plru.sv
module xc_plru
  import xc_pkg::*;
(
  input  logic [PLRU_W-1:0] state,
  input  logic [WAY_W-1:0]  touch,
  output logic [PLRU_W-1:0] next,
  output logic [WAY_W-1:0]  victim
);
  // bit0: root, bit1: left pair, bit2: right pair
  always_comb begin
    victim = state[0] ? {1'b1, state[2]} : {1'b0, state[1]};
    next   = state;
    if (!touch[1]) begin
      next[0] = 1'b1;
      next[1] = ~touch[0];
    end else begin
      next[0] = 1'b0;
      next[2] = ~touch[0];
    end
  end
endmodule

// File: rtl/xc_tlb.sv
module xc_tlb
  import xc_pkg::*;
#(
  parameter int SETS  = 16,
  parameter int VPN_W = 20
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   lk_en,
  input  logic [VPN_W-1:0]       lk_vpn,
  input  logic [OFF_W-1:0]       lk_off,
  output logic                   hit,
  output logic                   miss,
  output logic [VPN_W+OFF_W-1:0] pa,
  output logic [OFF_W-1:0]       perm,
  output logic                   dir_hit,
  output logic [VPN_W+OFF_W-1:0] dir_word,
  input  logic                   fill_en,
  input  logic                   fill_is_dir,
  input  logic [VPN_W-1:0]       fill_vpn,
  input  logic [VPN_W+OFF_W-1:0] fill_word,
  input  logic                   flush_task,
  input  logic                   flush_all
);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = VPN_W - IDX_W;
  localparam int WORD_W = VPN_W + OFF_W;

  logic [WAYS-1:0]   vld_q  [SETS];
  logic [WAYS-1:0]   dir_q  [SETS];
  logic [PLRU_W-1:0] plru_q [SETS];
  logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
  logic [WORD_W-1:0] word_q [SETS][WAYS];

  logic [IDX_W-1:0] lk_idx, f_idx;
  logic [TAG_W-1:0] lk_tag, f_tag;
  assign lk_idx = lk_vpn[IDX_W-1:0];
  assign lk_tag = lk_vpn[VPN_W-1:IDX_W];
  assign f_idx  = fill_vpn[IDX_W-1:0];
  assign f_tag  = fill_vpn[VPN_W-1:IDX_W];

  logic [WAYS-1:0][TAG_W-1:0]  rd_tags;
  logic [WAYS-1:0][WORD_W-1:0] rd_words;
  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      rd_tags[w]  = tag_q[lk_idx][w];
      rd_words[w] = word_q[lk_idx][w];
    end
  end

  logic              pte_any, pde_any;
  logic [WAY_W-1:0]  pte_way, pde_way;
  logic [WORD_W-1:0] pte_word, pde_word;

  xc_way_match #(.TAG_W(TAG_W), .WORD_W(WORD_W)) u_match (
    .vld      (vld_q[lk_idx]),
    .is_dir   (dir_q[lk_idx]),
    .tags     (rd_tags),
    .words    (rd_words),
    .key      (lk_tag),
    .pte_any  (pte_any),
    .pte_way  (pte_way),
    .pte_word (pte_word),
    .pde_any  (pde_any),
    .pde_way  (pde_way),
    .pde_word (pde_word)
  );

  assign hit      = lk_en && pte_any;
  assign miss     = lk_en && !pte_any;
  assign dir_hit  = lk_en && pde_any;
  assign pa       = {pte_word[WORD_W-1:OFF_W], lk_off};
  assign perm     = pte_word[OFF_W-1:0];
  assign dir_word = pde_word;

  // pseudo-LRU for the looked-up set
  logic [WAY_W-1:0]  lk_touch, lk_victim_unused;
  logic [PLRU_W-1:0] lk_plru_nxt;
  assign lk_touch = pte_any ? pte_way : pde_way;

  xc_plru u_plru_lk (
    .state  (plru_q[lk_idx]),
    .touch  (lk_touch),
    .next   (lk_plru_nxt),
    .victim (lk_victim_unused)
  );

  // refill way selection
  logic [WAY_W-1:0]  f_victim, f_way;
  logic [PLRU_W-1:0] f_plru_nxt;
  logic              f_has_free;
  logic [WAY_W-1:0]  f_free;

  always_comb begin
    f_has_free = 1'b0;
    f_free     = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!vld_q[f_idx][w]) begin
        f_has_free = 1'b1;
        f_free     = WAY_W'(w);
      end
    end
  end

  assign f_way = f_has_free ? f_free : f_victim;

  xc_plru u_plru_fill (
    .state  (plru_q[f_idx]),
    .touch  (f_way),
    .next   (f_plru_nxt),
    .victim (f_victim)
  );

  logic fill_wr;
  assign fill_wr = fill_en && !flush_task && !flush_all;

  // valid, flag and replacement state
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s]  <= '0;
        dir_q[s]  <= '0;
        plru_q[s] <= '0;
      end
    end else if (flush_all) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else if (flush_task) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          if (!word_q[s][w][GLOBAL_BIT]) vld_q[s][w] <= 1'b0;
    end else begin
      if (lk_en && (pte_any || pde_any)) plru_q[lk_idx] <= lk_plru_nxt;
      if (fill_wr) begin
        vld_q[f_idx][f_way] <= 1'b1;
        dir_q[f_idx][f_way] <= fill_is_dir;
        plru_q[f_idx]       <= f_plru_nxt;
      end
    end
  end

  // tag and word storage, no reset
  always_ff @(posedge clk) begin
    if (fill_wr) begin
      tag_q[f_idx][f_way]  <= f_tag;
      word_q[f_idx][f_way] <= fill_word;
    end
  end
endmodule

// File: rtl/xc_tlb_chk.sv
module xc_tlb_chk #(
  parameter int VPN_W = 20,
  parameter int OFF_W = 12
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   lk_en,
  input logic [VPN_W-1:0]       lk_vpn,
  input logic [OFF_W-1:0]       lk_off,
  input logic                   hit,
  input logic                   miss,
  input logic [VPN_W+OFF_W-1:0] pa,
  input logic                   dir_hit,
  input logic                   fill_en,
  input logic                   fill_is_dir,
  input logic [VPN_W-1:0]       fill_vpn,
  input logic                   flush_task,
  input logic                   flush_all
);
  // R1: first cycle out of reset sees an empty buffer
  a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!hit && !dir_hit));

  // R3: offset passes through unchanged on a hit
  a_r3_offset_passthru: assert property (@(posedge clk) disable iff (rst)
    hit |-> (pa[OFF_W-1:0] == lk_off));

  // R3: a table-level refill is visible to the next lookup of its page
  a_r3_fill_then_hit: assert property (@(posedge clk) disable iff (rst)
    (fill_en && !fill_is_dir && !flush_task && !flush_all)
      |=> (!lk_en || lk_vpn != $past(fill_vpn) || hit));

  // R9: nothing survives an invalidate-all
  a_r9_flush_all_empties: assert property (@(posedge clk) disable iff (rst)
    flush_all |=> (!hit && !dir_hit));

  // R4: an active lookup always reports either a hit or a miss
  a_r4_hit_or_miss: assert property (@(posedge clk) disable iff (rst)
    lk_en |-> $countones({hit, miss}) == 1);
endmodule

bind xc_tlb xc_tlb_chk #(.VPN_W(VPN_W), .OFF_W(xc_pkg::OFF_W)) u_chk (
  .clk(clk), .rst(rst), .lk_en(lk_en), .lk_vpn(lk_vpn), .lk_off(lk_off),
  .hit(hit), .miss(miss), .pa(pa), .dir_hit(dir_hit), .fill_en(fill_en),
  .fill_is_dir(fill_is_dir), .fill_vpn(fill_vpn),
  .flush_task(flush_task), .flush_all(flush_all)
);

// File: tb/xc_tlb_bench.sv
`timescale 1ns/1ps
module xc_tlb_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_en = 1'b0;
  logic [19:0] lk_vpn = '0;
  logic [11:0] lk_off = '0;
  logic        hit, miss, dir_hit;
  logic [31:0] pa, dir_word;
  logic [11:0] perm;
  logic        fill_en = 1'b0, fill_is_dir = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [31:0] fill_word = '0;
  logic        flush_task = 1'b0, flush_all = 1'b0;

  always #2.5 clk = ~clk;

  xc_tlb u_xc_tlb (
    .clk(clk), .rst(rst), .lk_en(lk_en), .lk_vpn(lk_vpn), .lk_off(lk_off),
    .hit(hit), .miss(miss), .pa(pa), .perm(perm), .dir_hit(dir_hit),
    .dir_word(dir_word), .fill_en(fill_en), .fill_is_dir(fill_is_dir),
    .fill_vpn(fill_vpn), .fill_word(fill_word), .flush_task(flush_task),
    .flush_all(flush_all)
  );

  typedef struct {
    logic        e_hit;
    logic [31:0] e_pa;
    logic [11:0] e_perm;
    logic        e_dir;
    logic [31:0] e_dword;
    string       req;
  } exp_t;

  exp_t q[$];
  int   n_run = 0, n_fail = 0;
  bit   done = 0;

  // monitor: compare on the falling edge while a lookup is held
  always @(negedge clk) begin
    if (lk_en && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_run++;
      if (hit !== e.e_hit || miss !== !e.e_hit || dir_hit !== e.e_dir ||
          (e.e_hit && (pa !== e.e_pa || perm !== e.e_perm)) ||
          (e.e_dir && dir_word !== e.e_dword)) begin
        n_fail++;
        $display("FAIL %s vpn=%h: hit=%b pa=%h perm=%h dir=%b dw=%h exp hit=%b pa=%h perm=%h dir=%b dw=%h",
                 e.req, lk_vpn, hit, pa, perm, dir_hit, dir_word,
                 e.e_hit, e.e_pa, e.e_perm, e.e_dir, e.e_dword);
      end
    end
  end

  task automatic fill(input logic [19:0] v, input logic [31:0] w, input logic d,
                      input logic ft = 1'b0, input logic fa = 1'b0);
    @(posedge clk); #1;
    fill_en = 1'b1; fill_vpn = v; fill_word = w; fill_is_dir = d;
    flush_task = ft; flush_all = fa;
    @(posedge clk); #1;
    fill_en = 1'b0; flush_task = 1'b0; flush_all = 1'b0;
  endtask

  task automatic flush(input logic ft, input logic fa);
    @(posedge clk); #1;
    flush_task = ft; flush_all = fa;
    @(posedge clk); #1;
    flush_task = 1'b0; flush_all = 1'b0;
  endtask

  // driver: push expectation, hold lookup for one cycle
  task automatic look(input logic [19:0] v, input logic [11:0] off,
                      input logic eh, input logic [31:0] pte,
                      input logic ed, input logic [31:0] pde, input string req);
    exp_t e;
    e.e_hit = eh; e.e_pa = {pte[31:12], off}; e.e_perm = pte[11:0];
    e.e_dir = ed; e.e_dword = pde; e.req = req;
    @(posedge clk); #1;
    q.push_back(e);
    lk_en = 1'b1; lk_vpn = v; lk_off = off;
    @(posedge clk); #1;
    lk_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    rst = 1'b0;
    // R1
    look(20'h12345, 12'h000, 0, 0, 0, 0, "R1");
    look(20'h00000, 12'h000, 0, 0, 0, 0, "R1");
    // R3 basic translation
    fill(20'h12345, 32'hABCDE007, 1'b0);
    look(20'h12345, 12'h678, 1, 32'hABCDE007, 0, 0, "R3");
    // R2 same set, different tag
    look(20'h22345, 12'h678, 0, 0, 0, 0, "R2");
    // R4 directory-only match
    fill(20'h00020, 32'h13579001, 1'b1);
    look(20'h00020, 12'h010, 0, 0, 1, 32'h13579001, "R4");
    // R5 both kinds, same tag
    fill(20'h12345, 32'h24680003, 1'b1);
    look(20'h12345, 12'hFFF, 1, 32'hABCDE007, 1, 32'h24680003, "R5");
    // R6 fill set 3 through free ways 0..3
    for (int t = 1; t <= 4; t++)
      fill({16'(t), 4'h3}, {20'hA0000 + 20'(t), 12'h003}, 1'b0);
    for (int t = 1; t <= 4; t++)
      look({16'(t), 4'h3}, 12'h123, 1, {20'hA0000 + 20'(t), 12'h003}, 0, 0, "R6");
    // After fills and the hits above (ways 0..3 in turn) the tree is 000.
    // Touch way 0 (tag 1): root->1, left->1, victim becomes way 2 (tag 3).
    look({16'd1, 4'h3}, 12'h000, 1, 32'hA0001003, 0, 0, "R7");
    fill({16'd5, 4'h3}, 32'hA0005003, 1'b0);
    look({16'd3, 4'h3}, 12'h000, 0, 0, 0, 0, "R7");
    look({16'd5, 4'h3}, 12'h001, 1, 32'hA0005003, 0, 0, "R7");
    look({16'd1, 4'h3}, 12'h002, 1, 32'hA0001003, 0, 0, "R7");
    look({16'd2, 4'h3}, 12'h003, 1, 32'hA0002003, 0, 0, "R7");
    look({16'd4, 4'h3}, 12'h004, 1, 32'hA0004003, 0, 0, "R7");
    // R8 global survives task flush (bit 8 set)
    fill(20'h0AAA7, 32'h55555107, 1'b0);
    fill(20'h0BBB7, 32'h66666003, 1'b0);
    flush(1'b1, 1'b0);
    look(20'h0AAA7, 12'h321, 1, 32'h55555107, 0, 0, "R8");
    look(20'h0BBB7, 12'h321, 0, 0, 0, 0, "R8");
    look(20'h12345, 12'h321, 0, 0, 0, 0, "R8");
    // R9 invalidate-all removes global too
    flush(1'b0, 1'b1);
    look(20'h0AAA7, 12'h321, 0, 0, 0, 0, "R9");
    // R10 refill during a flush is dropped
    fill(20'h0CCC9, 32'h77777103, 1'b0, 1'b1, 1'b0);
    look(20'h0CCC9, 12'h000, 0, 0, 0, 0, "R10");
    fill(20'h0DDD9, 32'h88888103, 1'b0, 1'b0, 1'b1);
    look(20'h0DDD9, 12'h000, 0, 0, 0, 0, "R10");
    repeat (2) @(posedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule